// File: doc/BRIEF.md
# Lane-Split Partial-Write Register Bank

This block is a general-purpose register file of 64-bit words. Each word is stored as five lanes of uneven width, and each lane has its own write enable. The lanes are bits 7:0, 15:8, 31:16, 47:32 and 63:48. A write changes only the lanes it enables and leaves the others as they were. Two kinds of partial write depend on this layout. The first is a size-limited write of the low 8, 16, 32 or 64 bits. The second is a 16-bit constant placed into one of four 16-bit slots.

A write-kind decoder turns a 4-bit code into the five-bit lane-enable mask. The data steering logic puts the write data on the right lanes: it is aligned at bit 0 for size writes, shifted into a slot for constant inserts, or shifted and sign-extended upward for extending inserts. A raw mask input can take the place of the decoded mask, while data steering still follows the write kind. The word is then read back through two combinational read ports.

Top module: `lane_regbank`

## Requirements
- R1: A synchronous reset, held high at a rising clock edge, clears every register to zero.
- R2: Address 0 always reads as zero on both read ports, and writes to it have no effect.
- R3: Write kinds 0, 1, 2 and 3 write the low 8, 16, 32 and 64 bits of wr_data into the same bits of the register. All other bits keep their old value.
- R4: Write kinds 4, 5, 6 and 7 place wr_data[15:0] at bit offset 0, 16, 32 and 48 respectively. Only that 16-bit field changes.
- R5: Write kinds 8, 9, 10 and 11 place wr_data[15:0] at bit offset 0, 16, 32 and 48. Every bit above that field, up to bit 63, is loaded with wr_data[15]. Bits below the offset are kept.
- R6: Write kinds 12 to 15 decode to an empty lane mask, so the register is left unchanged.
- R7: With mask_ovr high, bit i of mask_raw alone enables lane i. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 31:16, lane 3 is bits 47:32 and lane 4 is bits 63:48. Lane data is still placed as the write kind prescribes, and kinds 12 to 15 use wr_data as it stands.
- R8: With wr_valid low, no register changes at the clock edge.
- R9: The two read ports work independently of each other. A read of the register being written returns the old value until the clock edge that commits the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Commit a write at this edge |
| wr_addr | input | 6 | Register written |
| wr_kind | input | 4 | Write kind code (R3 to R6) |
| wr_data | input | 64 | Write data |
| mask_ovr | input | 1 | Use mask_raw in place of the decoded mask |
| mask_raw | input | 5 | Raw lane enables, one bit per lane |
| rd_a_addr | input | 6 | Read port A address |
| rd_a_data | output | 64 | Read port A data |
| rd_b_addr | input | 6 | Read port B address |
| rd_b_data | output | 64 | Read port B data |

## Verification
A read and a write can target the same register in the same cycle. In that case the read port must still show the old word while the write waits for the clock edge. Every write in the bench points read port A at the target register. The bench checks port A before the edge against the value the reference model held before the write, and checks it again after the edge against the merged value. A partial write changes only some lanes, so a bad merge of kept and new lanes shows up in the second check.

// File: rtl/lane_regbank.sv
module lane_regbank #(
  parameter int NREGS = 64,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_kind,
  input  logic [63:0]   wr_data,
  input  logic          mask_ovr,
  input  logic [4:0]    mask_raw,
  input  logic [AW-1:0] rd_a_addr,
  output logic [63:0]   rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [63:0]   rd_b_data
);
  localparam int XLEN = 64;

  logic [XLEN-1:0] regs [NREGS];
  logic [4:0]      dec_mask;
  logic [4:0]      lane_en;
  logic [5:0]      shamt;
  logic [XLEN-1:0] ins_data;
  logic [XLEN-1:0] ext_data;
  logic [XLEN-1:0] placed;
  logic [XLEN-1:0] bit_en;

  always_comb begin
    case (wr_kind)
      4'd0:    dec_mask = 5'b00001;
      4'd1:    dec_mask = 5'b00011;
      4'd2:    dec_mask = 5'b00111;
      4'd3:    dec_mask = 5'b11111;
      4'd4:    dec_mask = 5'b00011;
      4'd5:    dec_mask = 5'b00100;
      4'd6:    dec_mask = 5'b01000;
      4'd7:    dec_mask = 5'b10000;
      4'd8:    dec_mask = 5'b11111;
      4'd9:    dec_mask = 5'b11100;
      4'd10:   dec_mask = 5'b11000;
      4'd11:   dec_mask = 5'b10000;
      default: dec_mask = 5'b00000;
    endcase
  end

  assign lane_en  = mask_ovr ? mask_raw : dec_mask;
  assign shamt    = {wr_kind[1:0], 4'b0000};
  assign ins_data = {48'b0, wr_data[15:0]} << shamt;
  assign ext_data = {{48{wr_data[15]}}, wr_data[15:0]} << shamt;

  always_comb begin
    case (wr_kind[3:2])
      2'd1:    placed = ins_data;
      2'd2:    placed = ext_data;
      default: placed = wr_data;
    endcase
  end

  assign bit_en = {{16{lane_en[4]}}, {16{lane_en[3]}}, {16{lane_en[2]}},
                   {8{lane_en[1]}}, {8{lane_en[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_valid && wr_addr != '0) begin
      regs[wr_addr] <= (regs[wr_addr] & ~bit_en) | (placed & bit_en);
    end
  end

  assign rd_a_data = (rd_a_addr == '0) ? '0 : regs[rd_a_addr];
  assign rd_b_data = (rd_b_addr == '0) ? '0 : regs[rd_b_addr];
endmodule

module lane_regbank_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [3:0]    wr_kind,
  input logic [63:0]   wr_data,
  input logic          mask_ovr,
  input logic [4:0]    mask_raw,
  input logic [AW-1:0] rd_a_addr,
  input logic [63:0]   rd_a_data,
  input logic [AW-1:0] rd_b_addr,
  input logic [63:0]   rd_b_data
);
  logic hit_a;
  assign hit_a = wr_valid && wr_addr != '0 && rd_a_addr == wr_addr;

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == 64'd0 && rd_b_data == 64'd0));

  a_r2_zero_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == '0) |=> (rd_b_addr != '0 || rd_b_data == 64'd0));

  a_r3_byte_write: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !mask_ovr && wr_kind == 4'd0) |=>
    (rd_a_addr != $past(rd_a_addr) ||
     rd_a_data == {$past(rd_a_data[63:8]), $past(wr_data[7:0])}));

  a_r4_insert_slot1: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !mask_ovr && wr_kind == 4'd5) |=>
    (rd_a_addr != $past(rd_a_addr) ||
     rd_a_data == {$past(rd_a_data[63:32]), $past(wr_data[15:0]), $past(rd_a_data[15:0])}));

  a_r5_extend_top: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !mask_ovr && wr_kind == 4'd11) |=>
    (rd_a_addr != $past(rd_a_addr) ||
     rd_a_data == {$past(wr_data[15:0]), $past(rd_a_data[47:0])}));

  a_r6_bad_kind_keeps: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !mask_ovr && wr_kind >= 4'd12) |=>
    (rd_a_addr != $past(rd_a_addr) || rd_a_data == $past(rd_a_data)));

  a_r7_empty_raw_keeps: assert property (@(posedge clk) disable iff (rst)
    (hit_a && mask_ovr && mask_raw == 5'd0) |=>
    (rd_a_addr != $past(rd_a_addr) || rd_a_data == $past(rd_a_data)));

  a_r8_idle_keeps: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid) |=>
    (rd_b_addr != $past(rd_b_addr) || rd_b_data == $past(rd_b_data)));
endmodule

bind lane_regbank lane_regbank_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_lane_regbank.sv
module test_lane_regbank;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [5:0]  wr_addr;
  logic [3:0]  wr_kind;
  logic [63:0] wr_data;
  logic        mask_ovr;
  logic [4:0]  mask_raw;
  logic [5:0]  rd_a_addr;
  logic [63:0] rd_a_data;
  logic [5:0]  rd_b_addr;
  logic [63:0] rd_b_data;

  logic [63:0] model [64];
  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  lane_regbank i_lane_regbank (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_kind(wr_kind), .wr_data(wr_data), .mask_ovr(mask_ovr),
    .mask_raw(mask_raw), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  function automatic int lane_lo(int l);
    return (l < 2) ? 8 * l : 16 * (l - 1);
  endfunction

  function automatic int lane_hi(int l);
    return (l == 0) ? 7 : (l == 1) ? 15 : 16 * l - 1;
  endfunction

  function automatic logic [63:0] expect_word(logic [63:0] old, int kind,
      logic [63:0] d, logic ovr, logic [4:0] raw);
    logic [63:0] bm = '0;
    logic [63:0] pd = d;
    int s = (kind % 4) * 16;
    if (kind < 4) begin
      for (int b = 0; b < (8 << kind); b++) bm[b] = 1'b1;
    end else if (kind < 8) begin
      for (int b = s; b < s + 16; b++) bm[b] = 1'b1;
      pd = {48'b0, d[15:0]} << s;
    end else if (kind < 12) begin
      for (int b = s; b < 64; b++) bm[b] = 1'b1;
      pd = {{48{d[15]}}, d[15:0]} << s;
    end
    if (ovr) begin
      bm = '0;
      for (int l = 0; l < 5; l++)
        if (raw[l]) for (int b = lane_lo(l); b <= lane_hi(l); b++) bm[b] = 1'b1;
    end
    return (old & ~bm) | (pd & bm);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, int kind, logic [63:0] d,
      logic ovr, logic [4:0] raw, string tag);
    logic [5:0] rb = a ^ 6'h15;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_kind = 4'(kind); wr_data = d;
    mask_ovr = ovr; mask_raw = raw; rd_a_addr = a; rd_b_addr = rb;
    #1;
    check("R9 port A old value during write", rd_a_data, model[a]);
    check("R9 port B independent read", rd_b_data, model[rb]);
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    if (a != 6'd0) model[a] = expect_word(model[a], kind, d, ovr, raw);
    check(tag, rd_a_data, model[a]);
  endtask

  task automatic check_all_zero();
    for (int r = 0; r < 64; r++) begin
      rd_a_addr = 6'(r); rd_b_addr = 6'(63 - r);
      #1;
      check("R1 reset clears port A", rd_a_data, 64'd0);
      check("R1 reset clears port B", rd_b_data, 64'd0);
    end
  endtask

  function automatic logic [63:0] pat(int p);
    return 64'h0123_4567_89AB_CDEF ^ (64'(p) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_kind = '0; wr_data = '0;
    mask_ovr = 1'b0; mask_raw = '0; rd_a_addr = '0; rd_b_addr = '0;
    for (int r = 0; r < 64; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    check_all_zero();

    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 6; p++) begin
        logic [5:0] a = 6'(1 + (k * 6 + p) % 63);
        string tag = (k < 4) ? "R3 size write" : (k < 8) ? "R4 constant insert" :
                     (k < 12) ? "R5 extending insert" : "R6 unused kind keeps";
        do_write(a, 3, ~pat(p + 40), 1'b0, 5'd0, "R3 full preload");
        do_write(a, k, pat(p) ^ (64'(p & 1) << 15), 1'b0, 5'd0, tag);
      end
    end

    for (int raw = 0; raw < 32; raw++) begin
      for (int j = 0; j < 4; j++) begin
        int kinds [4] = '{1, 6, 10, 14};
        logic [5:0] a = 6'(1 + (raw * 4 + j) % 63);
        do_write(a, 3, pat(raw + 7), 1'b0, 5'd0, "R3 full preload");
        do_write(a, kinds[j], ~pat(raw * 3 + j), 1'b1, 5'(raw), "R7 raw mask override");
      end
    end

    for (int k = 0; k < 12; k++)
      do_write(6'd0, k, pat(k), (k % 2) == 1, 5'h1F, "R2 register zero ignores write");

    for (int n = 0; n < 8; n++) begin
      logic [5:0] a = 6'(5 + n * 7);
      @(negedge clk);
      wr_valid = 1'b0; wr_addr = a; wr_kind = 4'd3; wr_data = pat(n + 90);
      mask_ovr = 1'b0; rd_a_addr = a;
      @(posedge clk);
      #1;
      check("R8 idle write port leaves register", rd_a_data, model[a]);
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1; rst = 1'b0;
    for (int r = 0; r < 64; r++) model[r] = '0;
    check_all_zero();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule